// File: doc/BRIEF.md
# Temperature-Proportional Fan PWM Controller

This block drives one fan switch with a pulse-width-modulated output whose duty follows a temperature reading. An external converter delivers an 8-bit reading along with a one-cycle valid strobe. The block holds the latest reading and maps it onto a duty value. Below a cool threshold the duty stays at a floor, so the fan never stalls. Between the cool and hot thresholds the duty climbs in a straight line. At or above the hot threshold the duty is full.

Two conditions override the temperature and force full speed. The first is a start-up interval after reset, timed by a prescaled clock, during which the fans spin up reliably. The second is a reading below the code that stands for 0 °C, which the block treats as a failed sensor. A new duty value takes effect only when the PWM counter wraps, so a change never produces a stray pulse.

The reading-to-temperature mapping is set by parameters: the code for 0 °C, the number of codes per degree, and the two threshold temperatures. With the defaults, 0 °C is code 20, the scale is 2 codes per degree, 30 °C is code 80 and 61 °C is code 142.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: While rstN is low, and directly after it is released, pwmOut is held high (full duty).
- R2: For STARTUP_TICKS x PRESCALE_DIV clock cycles after reset is released, pwmOut stays continuously high whatever reading arrives.
- R3: For a reading at least ZERO_CODE and at most LOW_CODE (ZERO_CODE + LOW_DEG x CODES_PER_DEG), the output is high for exactly MIN_DUTY cycles of every 2^PWM_BITS-cycle period.
- R4: For a reading at or above HIGH_CODE (ZERO_CODE + HIGH_DEG x CODES_PER_DEG), pwmOut is continuously high.
- R5: For a reading strictly between LOW_CODE and HIGH_CODE, the high time per period is MIN_DUTY + floor((code - LOW_CODE) x (2^PWM_BITS - MIN_DUTY) / (HIGH_CODE - LOW_CODE)).
- R6: A reading below ZERO_CODE is a sensor fault, and pwmOut is continuously high.
- R7: Until the first valid reading after reset, the held reading is 255, which gives full duty.
- R8: A new duty value takes effect only at the wrap of the PWM counter. In every period with duty below full there is exactly one rising edge of pwmOut, at the start of the period.
- R9: The PWM period is 2^PWM_BITS clock cycles. The output is high for the first duty cycles of each period.
- R10: sampleCode is captured only in a cycle where sampleValid is high. Changes to it at other times have no effect on pwmOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new reading |
| sampleCode | input | TEMP_BITS | Temperature reading from the converter |
| pwmOut | output | 1 | Fan switch drive, high = fan on |

## Verification
The hardest situation to reach is a reading that changes partway through a PWM period. This is the only case where a duty update that ignored the wrap would cut the pulse short or add a second rising edge. The bench cannot see the counter phase. It therefore sends alternating low-duty and high-duty readings at varying offsets within the period, and counts the rising edges and high cycles over whole periods. A second hard case is the start-up override expiring. The bench sends a cool reading early, then measures how long pwmOut stays high before its first low cycle.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  // Strobes from the sequencing control to the duty datapath
  typedef struct packed {
    logic capture;    // latch sampleCode this cycle
    logic forceFull;  // start-up override active
    logic loadDuty;   // PWM counter is about to wrap
  } ctlStrobes_t;
endpackage

// File: rtl/fan_pwm_seq.sv
module fan_pwm_seq
  import fan_pwm_pkg::*;
#(
  parameter int PWM_BITS      = 8,
  parameter int PRESCALE_DIV  = 50000,
  parameter int STARTUP_TICKS = 3000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  output ctlStrobes_t         strobes,
  output logic [PWM_BITS-1:0] pwmPhase
);
  localparam int PRE_W = $clog2(PRESCALE_DIV + 1);
  localparam int UP_W  = $clog2(STARTUP_TICKS + 1);
  localparam logic [PRE_W-1:0]    PRE_LAST  = PRE_W'(PRESCALE_DIV - 1);
  localparam logic [UP_W-1:0]     UP_LAST   = UP_W'(STARTUP_TICKS);
  localparam logic [PWM_BITS-1:0] PHASE_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [UP_W-1:0]  upCnt;
  logic             startupDone;
  logic             tick;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upCnt       <= '0;
      startupDone <= 1'b0;
    end else if (!startupDone && tick) begin
      upCnt <= upCnt + 1'b1;
      if (upCnt == UP_LAST - 1'b1) startupDone <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwmPhase <= '0;
    else       pwmPhase <= pwmPhase + 1'b1;
  end

  always_comb begin
    strobes.capture   = sampleValid;
    strobes.forceFull = !startupDone;
    strobes.loadDuty  = (pwmPhase == PHASE_MAX);
  end
endmodule

// File: rtl/fan_pwm_dp.sv
module fan_pwm_dp
  import fan_pwm_pkg::*;
#(
  parameter int PWM_BITS      = 8,
  parameter int TEMP_BITS     = 8,
  parameter int ZERO_CODE     = 20,
  parameter int CODES_PER_DEG = 2,
  parameter int LOW_DEG       = 30,
  parameter int HIGH_DEG      = 61,
  parameter int MIN_DUTY      = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [PWM_BITS-1:0]  pwmPhase,
  input  logic [TEMP_BITS-1:0] sampleCode,
  output logic [TEMP_BITS-1:0] heldCode,
  output logic [PWM_BITS:0]    activeDuty,
  output logic                 pwmOut
);
  localparam int DUTY_W = PWM_BITS + 1;
  localparam int FULL   = 1 << PWM_BITS;
  localparam int LOW_C  = ZERO_CODE + LOW_DEG * CODES_PER_DEG;
  localparam int HIGH_C = ZERO_CODE + HIGH_DEG * CODES_PER_DEG;
  localparam int SPAN   = HIGH_C - LOW_C;
  localparam int RISE   = FULL - MIN_DUTY;
  localparam int PROD_W = TEMP_BITS + DUTY_W + 1;

  localparam logic [TEMP_BITS-1:0] ZERO_V = TEMP_BITS'(ZERO_CODE);
  localparam logic [TEMP_BITS-1:0] LOW_V  = TEMP_BITS'(LOW_C);
  localparam logic [TEMP_BITS-1:0] HIGH_V = TEMP_BITS'(HIGH_C);
  localparam logic [DUTY_W-1:0]    FULL_V = DUTY_W'(FULL);
  localparam logic [DUTY_W-1:0]    MIN_V  = DUTY_W'(MIN_DUTY);
  localparam logic [PROD_W-1:0]    SPAN_V = PROD_W'(SPAN);
  localparam logic [PROD_W-1:0]    RISE_V = PROD_W'(RISE);

  logic                 sensorFault;
  logic [TEMP_BITS-1:0] aboveLow;
  logic [PROD_W-1:0]    scaled;
  logic [PROD_W-1:0]    step;
  logic [DUTY_W-1:0]    pendingDuty;

  // Reading register: resets to the top code, which maps to full duty
  always_ff @(posedge clk) begin
    if (!rstN)                heldCode <= '1;
    else if (strobes.capture) heldCode <= sampleCode;
  end

  assign sensorFault = (heldCode < ZERO_V);
  assign aboveLow    = heldCode - LOW_V;
  assign scaled      = PROD_W'(aboveLow) * RISE_V;
  assign step        = scaled / SPAN_V;

  always_comb begin
    if (strobes.forceFull || sensorFault || heldCode >= HIGH_V) begin
      pendingDuty = FULL_V;
    end else if (heldCode <= LOW_V) begin
      pendingDuty = MIN_V;
    end else begin
      pendingDuty = MIN_V + DUTY_W'(step);
    end
  end

  // Duty is only refreshed on the cycle before phase returns to zero
  always_ff @(posedge clk) begin
    if (!rstN)                 activeDuty <= FULL_V;
    else if (strobes.loadDuty) activeDuty <= pendingDuty;
  end

  assign pwmOut = ({1'b0, pwmPhase} < activeDuty);
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int PWM_BITS      = 8,
  parameter int TEMP_BITS     = 8,
  parameter int PRESCALE_DIV  = 50000,
  parameter int STARTUP_TICKS = 3000,
  parameter int ZERO_CODE     = 20,
  parameter int CODES_PER_DEG = 2,
  parameter int LOW_DEG       = 30,
  parameter int HIGH_DEG      = 61,
  parameter int MIN_DUTY      = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic [TEMP_BITS-1:0] sampleCode,
  output logic                 pwmOut
);
  ctlStrobes_t          strobes;
  logic [PWM_BITS-1:0]  pwmPhase;
  logic [TEMP_BITS-1:0] heldCode;
  logic [PWM_BITS:0]    activeDuty;

  fan_pwm_seq #(
    .PWM_BITS(PWM_BITS), .PRESCALE_DIV(PRESCALE_DIV), .STARTUP_TICKS(STARTUP_TICKS)
  ) uSeq (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strobes(strobes), .pwmPhase(pwmPhase)
  );

  fan_pwm_dp #(
    .PWM_BITS(PWM_BITS), .TEMP_BITS(TEMP_BITS), .ZERO_CODE(ZERO_CODE),
    .CODES_PER_DEG(CODES_PER_DEG), .LOW_DEG(LOW_DEG), .HIGH_DEG(HIGH_DEG),
    .MIN_DUTY(MIN_DUTY)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pwmPhase(pwmPhase),
    .sampleCode(sampleCode), .heldCode(heldCode), .activeDuty(activeDuty),
    .pwmOut(pwmOut)
  );
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
  parameter int PWM_BITS  = 8,
  parameter int TEMP_BITS = 8,
  parameter int ZERO_CODE = 20,
  parameter int MIN_DUTY  = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pwmOut,
  input logic                 forceFull,
  input logic [PWM_BITS-1:0]  pwmPhase,
  input logic [TEMP_BITS-1:0] heldCode,
  input logic [PWM_BITS:0]    activeDuty
);
  localparam logic [PWM_BITS:0]    FULL_V  = (PWM_BITS+1)'(1 << PWM_BITS);
  localparam logic [PWM_BITS:0]    MIN_V   = (PWM_BITS+1)'(MIN_DUTY);
  localparam logic [PWM_BITS-1:0]  LAST_PH = '1;
  localparam logic [TEMP_BITS-1:0] ZERO_V  = TEMP_BITS'(ZERO_CODE);

  // R1 / R2: override keeps the output high
  p_startup_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    forceFull |-> pwmOut);

  // R8: duty register only moves on the first cycle of a period
  p_duty_at_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmPhase != '0) |-> $stable(activeDuty));

  // R8: rising edge only at phase zero
  p_rise_at_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (pwmPhase == '0));

  // R3 / R4: duty kept within floor and full
  p_duty_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty >= MIN_V) && (activeDuty <= FULL_V));

  // R6: a faulty reading loaded at wrap gives full duty
  p_fault_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (heldCode < ZERO_V && pwmPhase == LAST_PH) |=> (activeDuty == FULL_V));
endmodule

bind fan_pwm_ctrl fan_pwm_chk #(
  .PWM_BITS(PWM_BITS), .TEMP_BITS(TEMP_BITS), .ZERO_CODE(ZERO_CODE), .MIN_DUTY(MIN_DUTY)
) uChk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .forceFull(strobes.forceFull),
  .pwmPhase(pwmPhase), .heldCode(heldCode), .activeDuty(activeDuty)
);

// File: tb/tb_fan_pwm_ctrl.sv
module tb_fan_pwm_ctrl;
  localparam int PWM_BITS = 8;
  localparam int PERIOD   = 1 << PWM_BITS;
  localparam int PRE_DIV  = 4;
  localparam int UP_TICKS = 150;
  localparam int START_CY = PRE_DIV * UP_TICKS;
  localparam int ZERO_C   = 20;
  localparam int LOW_C    = ZERO_C + 30 * 2;
  localparam int HIGH_C   = ZERO_C + 61 * 2;
  localparam int MIN_D    = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleCode = 8'd0;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(
    .PWM_BITS(PWM_BITS), .TEMP_BITS(8), .PRESCALE_DIV(PRE_DIV),
    .STARTUP_TICKS(UP_TICKS), .ZERO_CODE(ZERO_C), .CODES_PER_DEG(2),
    .LOW_DEG(30), .HIGH_DEG(61), .MIN_DUTY(MIN_D)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleCode(sampleCode), .pwmOut(pwmOut)
  );

  function automatic int expDuty(int code);
    if (code < ZERO_C)  return PERIOD;
    if (code >= HIGH_C) return PERIOD;
    if (code <= LOW_C)  return MIN_D;
    return MIN_D + ((code - LOW_C) * (PERIOD - MIN_D)) / (HIGH_C - LOW_C);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendCode(int code);
    @(negedge clk);
    sampleCode  = 8'(code);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // High cycles and rising edges over one full period
  task automatic measure(output int highs, output int rises);
    logic prev;
    highs = 0;
    rises = 0;
    @(negedge clk);
    prev = pwmOut;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
      if (pwmOut && !prev) rises++;
      prev = pwmOut;
    end
  endtask

  task automatic settle();
    repeat (2 * PERIOD + 8) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int h, r, cnt, code;
    void'($urandom(32'd4242));

    // R1: high while reset is asserted
    repeat (2) @(negedge clk);
    check("R1 in reset", int'(pwmOut), 1);
    doReset();
    @(negedge clk);
    check("R1 after release", int'(pwmOut), 1);

    // R2: cool reading during start-up is overridden
    sendCode(LOW_C - 10);
    measure(h, r);
    check("R2 startup high count", h, PERIOD);
    cnt = PERIOD + 6;
    while (pwmOut && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check("R2 override not shorter", int'(cnt >= START_CY), 1);
    check("R2 override ends", int'(cnt <= START_CY + PERIOD + MIN_D + 20), 1);
    settle();
    measure(h, r);
    check("R3 floor after startup", h, MIN_D);

    // R10: change code without strobe
    @(negedge clk);
    sampleCode = 8'd200;
    settle();
    measure(h, r);
    check("R10 unstrobed code ignored", h, MIN_D);

    // R3 boundary, R4 boundaries, R6 boundary, R5 just above low
    sendCode(LOW_C);      settle(); measure(h, r); check("R3 at low code", h, MIN_D);
    sendCode(ZERO_C);     settle(); measure(h, r); check("R3 at zero code", h, MIN_D);
    sendCode(ZERO_C - 1); settle(); measure(h, r); check("R6 below zero", h, PERIOD);
    sendCode(0);          settle(); measure(h, r); check("R6 code 0", h, PERIOD);
    sendCode(HIGH_C);     settle(); measure(h, r); check("R4 at high code", h, PERIOD);
    check("R4 no edge when full", r, 0);
    sendCode(HIGH_C - 1); settle(); measure(h, r);
    check("R5 just below high", h, expDuty(HIGH_C - 1));
    sendCode(LOW_C + 1);  settle(); measure(h, r);
    check("R5 just above low", h, expDuty(LOW_C + 1));
    check("R9 one pulse per period", r, 1);

    // R8: readings swapped at varying offsets within the period
    for (int k = 0; k < 12; k++) begin
      repeat (k * 23 + 1) @(negedge clk);
      sendCode((k % 2 == 0) ? LOW_C + 55 : LOW_C + 2);
      measure(h, r);
      check("R8 single rise with mid-period update", r, 1);
    end

    // Random readings: R3..R6
    for (int k = 0; k < 40; k++) begin
      code = int'($urandom_range(255, 0));
      sendCode(code);
      settle();
      measure(h, r);
      check("R5 random reading", h, expDuty(code));
    end

    // R7: no reading after reset
    doReset();
    repeat (START_CY + 3 * PERIOD) @(negedge clk);
    measure(h, r);
    check("R7 no reading yet", h, PERIOD);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule